// File: doc/BRIEF.md
# Multi-phase peak magnitude tracker

This block watches up to three signed sample streams belonging to one measurement channel, such as the three phase voltages or the three phase currents. It finds the largest absolute sample among the enabled phases over a window counted in half-line cycles. At the end of each window it publishes that magnitude, together with a one-hot tag naming the phase that produced it, in a 32-bit result word. It then starts the next window from zero. A chip uses one instance for its voltage channel and a second one for its current channel. The zero-crossing pulses come from a detector outside the block, and the result word is read through a bus interface that is also outside the block.

All selected phases advance one shared half-cycle counter. Selecting two or three phases therefore closes the window two or three times sooner for the same programmed count. The sample input is a valid-only stream with no back-pressure. The block accepts a sample set on every cycle where `smp_valid` is high and has no ready output. `phase_sel`, `half_cycles` and `zc` are plain control pins, sampled on every clock.

Top module: `peak_tracker`

## Requirements
- R1: After reset, `peak_result` reads 0, the running maximum is 0 and the half-cycle count is 0.
- R2: The magnitude of a sample is its absolute value. The most negative code 0x800000 saturates to 0x7FFFFF. For example, -1 gives 1 and 0x7FFFFF gives 0x7FFFFF.
- R3: Only phases whose bit in `phase_sel` is 1 (bit 0 = A, bit 1 = B, bit 2 = C) take part in the search, and only on cycles where `smp_valid` is 1.
- R4: Each cycle, the count grows by the number of `zc` pulses on selected phases. The window closes in the cycle where the count reaches the threshold. The threshold is `half_cycles`, except that 0 is treated as 1. Any excess over the threshold is dropped, and the count restarts at 0.
- R5: When a window closes, `peak_result` takes its new value on the next clock edge. The peak sits in bits 23:0, the one-hot tag sits in bits 26:24 (24 = A, 25 = B, 26 = C), and bits 31:27 are 0. Samples taken in the closing cycle belong to the closing window.
- R6: After each publish, the running maximum and the tag restart from zero. If no selected magnitude in a window exceeds zero, the window publishes peak 0 with tag 000.
- R7: A new maximum replaces the old one only if it is strictly greater. The earlier holder wins a tie. When phases tie within one cycle, the lowest letter wins (A before B before C).
- R8: While `phase_sel` is 0, the count holds its value and `peak_result` stays unchanged.
- R9: Between window closes, `peak_result` holds its last published value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Sample set valid on all three phases |
| smp_a | input | 24 | Phase A sample, signed |
| smp_b | input | 24 | Phase B sample, signed |
| smp_c | input | 24 | Phase C sample, signed |
| zc | input | 3 | Zero-crossing pulses, bit 0 = A, bit 1 = B, bit 2 = C |
| phase_sel | input | 3 | Phase enable mask, same bit order as `zc` |
| half_cycles | input | 8 | Window length in half-line cycles (0 acts as 1) |
| peak_result | output | 32 | Published result: {5'b0, tag[2:0], peak[23:0]} |

## Verification
The bench builds the block with its default parameters: 24-bit samples, an 8-bit half-cycle count and three phases. These defaults place the tag at bits 26:24 and make 0x800000 the saturating code. Random runs draw short windows of 0 to 6 half cycles with sparse zero-crossing pulses, so that many windows close and threshold overshoot from simultaneous pulses occurs. Directed segments cover the boundary cases: saturation, ties within one cycle and across cycles, an all-zero window, and a held counter with no phase selected.

// File: rtl/peak_pkg.sv
package peak_pkg;
  localparam int unsigned PH_A = 0;
  localparam int unsigned PH_B = 1;
  localparam int unsigned PH_C = 2;
  localparam int unsigned NUM_PH = 3;
endpackage

// File: rtl/phase_mag.sv
module phase_mag #(
  parameter int unsigned W = 24
) (
  input  logic signed [W-1:0] smp,
  output logic        [W-1:0] mag
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

  always_comb begin
    if (smp == MOST_NEG)  mag = MOST_POS;
    else if (smp[W-1])    mag = -smp;
    else                  mag = smp;
  end
endmodule

// File: rtl/window_ctr.sv
module window_ctr #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned NPH    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPH-1:0]   zc,
  input  logic [NPH-1:0]   sel,
  input  logic [CNT_W-1:0] half_cycles,
  output logic             win_end
);
  localparam int unsigned SUM_W = CNT_W + $clog2(NPH + 1);

  logic [CNT_W-1:0] cnt;
  logic [SUM_W-1:0] hits;
  logic [SUM_W-1:0] total;
  logic [SUM_W-1:0] thr;

  always_comb begin
    hits = '0;
    for (int i = 0; i < NPH; i++)
      if (zc[i] && sel[i]) hits = hits + 1'b1;
    total = SUM_W'(cnt) + hits;
    thr   = (half_cycles == '0) ? SUM_W'(1) : SUM_W'(half_cycles);
    win_end = (hits != '0) && (total >= thr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (win_end)  cnt <= '0;
    else               cnt <= total[CNT_W-1:0];
  end

  assert_nosel_noend_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == '0) |-> !win_end);
  assert_nosel_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == '0) |=> $stable(cnt));
endmodule

// File: rtl/peak_search.sv
module peak_search #(
  parameter int unsigned W   = 24,
  parameter int unsigned NPH = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_valid,
  input  logic [NPH-1:0]          sel,
  input  logic [NPH-1:0][W-1:0]   mags,
  input  logic                    clear,
  output logic [W-1:0]            nxt_max,
  output logic [NPH-1:0]          nxt_tag
);
  logic [W-1:0]   run_max;
  logic [NPH-1:0] run_tag;

  always_comb begin
    nxt_max = run_max;
    nxt_tag = run_tag;
    for (int i = 0; i < NPH; i++) begin
      if (smp_valid && sel[i] && (mags[i] > nxt_max)) begin
        nxt_max = mags[i];
        nxt_tag = NPH'(1) << i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_max <= '0;
      run_tag <= '0;
    end else if (clear) begin
      run_max <= '0;
      run_tag <= '0;
    end else begin
      run_max <= nxt_max;
      run_tag <= nxt_tag;
    end
  end

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (run_max == '0) && (run_tag == '0));
  assert_max_monotone_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (run_max >= $past(run_max)));
  assert_tag_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(run_tag));
endmodule

// File: rtl/peak_tracker.sv
module peak_tracker #(
  parameter int unsigned SMP_W = 24,
  parameter int unsigned CNT_W = 8,
  parameter int unsigned RES_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_valid,
  input  logic signed [SMP_W-1:0] smp_a,
  input  logic signed [SMP_W-1:0] smp_b,
  input  logic signed [SMP_W-1:0] smp_c,
  input  logic [2:0]              zc,
  input  logic [2:0]              phase_sel,
  input  logic [CNT_W-1:0]        half_cycles,
  output logic [RES_W-1:0]        peak_result
);
  import peak_pkg::*;
  localparam int unsigned PAD_W = RES_W - SMP_W - NUM_PH;

  logic signed [NUM_PH-1:0][SMP_W-1:0] smp_vec;
  logic [NUM_PH-1:0][SMP_W-1:0]        mags;
  logic [SMP_W-1:0]                    nxt_max;
  logic [NUM_PH-1:0]                   nxt_tag;
  logic                                win_end;

  assign smp_vec[PH_A] = smp_a;
  assign smp_vec[PH_B] = smp_b;
  assign smp_vec[PH_C] = smp_c;

  for (genvar g = 0; g < NUM_PH; g++) begin : g_mag
    phase_mag #(.W(SMP_W)) u_mag (.smp(smp_vec[g]), .mag(mags[g]));
  end

  window_ctr #(.CNT_W(CNT_W), .NPH(NUM_PH)) u_win (
    .clk(clk), .rst_n(rst_n), .zc(zc), .sel(phase_sel),
    .half_cycles(half_cycles), .win_end(win_end)
  );

  peak_search #(.W(SMP_W), .NPH(NUM_PH)) u_search (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .sel(phase_sel),
    .mags(mags), .clear(win_end), .nxt_max(nxt_max), .nxt_tag(nxt_tag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       peak_result <= '0;
    else if (win_end) peak_result <= {{PAD_W{1'b0}}, nxt_tag, nxt_max};
  end

  assert_pad_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    peak_result[RES_W-1:SMP_W+NUM_PH] == '0);
  assert_result_tag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(peak_result[SMP_W+NUM_PH-1:SMP_W]));
  assert_tag_has_peak_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (peak_result[SMP_W+NUM_PH-1:SMP_W] != '0) |-> (peak_result[SMP_W-1:0] != '0));
  assert_peak_sat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    peak_result[SMP_W-1] == 1'b0);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(peak_result));
endmodule

// File: tb/tb_peak_tracker.sv
module tb_peak_tracker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic signed [23:0] smp_a = '0, smp_b = '0, smp_c = '0;
  logic [2:0] zc = '0, phase_sel = '0;
  logic [7:0] half_cycles = 8'd1;
  logic [31:0] peak_result;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string req = "R1";

  logic [23:0] m_max;
  logic [2:0]  m_tag;
  int          m_cnt;
  logic [31:0] m_res;

  always #10 clk = ~clk;

  peak_tracker dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_a(smp_a),
    .smp_b(smp_b), .smp_c(smp_c), .zc(zc), .phase_sel(phase_sel),
    .half_cycles(half_cycles), .peak_result(peak_result)
  );

  function automatic logic [23:0] magof(logic signed [23:0] s);
    if (s == 24'sh800000) return 24'h7FFFFF;
    if (s < 0) return -s;
    return s;
  endfunction

  task automatic check(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  // Drives one cycle: inputs are set at the negedge, the model is advanced,
  // and the result is compared at the following negedge.
  task automatic cyc(logic v, logic signed [23:0] a, logic signed [23:0] b,
                     logic signed [23:0] c, logic [2:0] z, logic [2:0] s, logic [7:0] h);
    logic signed [23:0] sv[3];
    int hits, thr;
    smp_valid = v; smp_a = a; smp_b = b; smp_c = c;
    zc = z; phase_sel = s; half_cycles = h;
    sv[0] = a; sv[1] = b; sv[2] = c;
    for (int i = 0; i < 3; i++)
      if (v && s[i] && magof(sv[i]) > m_max) begin
        m_max = magof(sv[i]);
        m_tag = 3'(1 << i);
      end
    hits = 0;
    for (int i = 0; i < 3; i++) if (z[i] && s[i]) hits++;
    thr = (h == 0) ? 1 : int'(h);
    if (hits != 0 && m_cnt + hits >= thr) begin
      m_res = {5'b0, m_tag, m_max};
      m_max = '0; m_tag = '0; m_cnt = 0;
    end else begin
      m_cnt = (m_cnt + hits) % 256;
    end
    @(negedge clk);
    check(req, peak_result, m_res);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    m_max = '0; m_tag = '0; m_cnt = 0; m_res = '0;
    repeat (3) @(negedge clk);
    req = "R1";
    check("R1", peak_result, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", peak_result, 32'h0);

    // R2: saturation and negative magnitudes
    req = "R2";
    cyc(1, 24'sh800000, 0, 0, 3'b001, 3'b001, 8'd1);
    check("R2", peak_result, {8'h01, 24'h7FFFFF});
    cyc(1, -24'sd1, 0, 0, 3'b001, 3'b001, 8'd1);
    check("R2", peak_result, {8'h01, 24'h000001});

    // R3: unselected phase and invalid strobe ignored
    req = "R3";
    cyc(0, 24'sh7FFFFF, 0, 0, 3'b000, 3'b001, 8'd1);
    cyc(1, 24'sd50, 24'sh7FFFFF, -24'sd900, 3'b001, 3'b001, 8'd1);
    check("R3", peak_result, {8'h01, 24'd50});

    // R4: shared counter, unselected crossings ignored, overshoot dropped
    req = "R4";
    cyc(1, 24'sd10, 24'sd20, 0, 3'b001, 3'b011, 8'd4);
    cyc(1, 0, 0, 0, 3'b100, 3'b011, 8'd4);
    cyc(1, 0, 0, 0, 3'b010, 3'b011, 8'd4);
    check("R4", peak_result, {8'h01, 24'd50});
    cyc(1, 0, 0, 0, 3'b011, 3'b011, 8'd4);
    check("R4", peak_result, {8'h02, 24'd20});
    cyc(1, 24'sd7, 0, 0, 3'b000, 3'b111, 8'd0);
    cyc(1, 0, 0, 0, 3'b100, 3'b111, 8'd0);
    check("R4", peak_result, {8'h01, 24'd7});

    // R7: same-cycle tie goes to lower letter; earlier holder keeps a tie
    req = "R7";
    cyc(1, 24'sd100, -24'sd100, 24'sd100, 3'b000, 3'b111, 8'd2);
    cyc(1, 0, 24'sd100, 0, 3'b011, 3'b111, 8'd2);
    check("R7", peak_result, {8'h01, 24'd100});
    cyc(1, 0, 24'sd100, 0, 3'b000, 3'b111, 8'd1);
    cyc(1, 24'sd100, 0, 24'sd100, 3'b001, 3'b111, 8'd1);
    check("R7", peak_result, {8'h02, 24'd100});

    // R6: empty window publishes zero with no tag
    req = "R6";
    cyc(1, 0, 0, 0, 3'b001, 3'b001, 8'd1);
    check("R6", peak_result, 32'h0);

    // R8: no selection holds counter and result
    req = "R8";
    cyc(1, 24'sd33, 0, 0, 3'b001, 3'b001, 8'd2);
    cyc(1, 24'sd999, 24'sd999, 24'sd999, 3'b111, 3'b000, 8'd2);
    cyc(1, 24'sd999, 24'sd999, 24'sd999, 3'b111, 3'b000, 8'd1);
    check("R8", peak_result, 32'h0);
    cyc(1, 0, 0, 0, 3'b001, 3'b001, 8'd2);
    check("R8", peak_result, {8'h01, 24'd33});

    // R9 and R5: random windows against the model
    req = "R5";
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] z, s;
      logic signed [23:0] a, b, c;
      z = 3'(($urandom % 4 == 0) ? $urandom : 0);
      s = 3'(($urandom % 8 == 0) ? 0 : $urandom);
      a = 24'($urandom); b = 24'($urandom); c = 24'($urandom);
      if ($urandom % 16 == 0) a = 24'sh800000;
      if ($urandom % 16 == 0) b = a;
      req = (n % 2 == 0) ? "R5" : "R9";
      cyc(1'($urandom), a, b, c, z, s, 8'($urandom % 7));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule